// File: doc/BRIEF.md
# Host Port Slave with Ready Handshake

This block lets an external host processor reach on-chip memory over a 16-bit half-word bus. The host picks one of three internal registers (control, address or data) with a two-bit select, identifies which half of a 32-bit word it is moving, and strobes the transfer. The block forms one composite strobe from its chip-select and two data strobes. It brings every host pin into the core clock through a synchronizer and detects strobe edges in that domain.

The control and address registers are plain host storage, written and read one half-word at a time. Data register traffic goes to an internal memory-access channel over a request/acknowledge port. A read fetches the word at the current address on the falling strobe of its first half. A write commits the assembled word after its second half. The autoincrement variant of the data register steps the address by one word per completed transfer, and on reads it also prefetches the following word. A busy output tells the host to stall while a memory transfer is outstanding. It is gated by chip-select.

Top module: `hostport_slave`

## Requirements
- R1: After reset the control, address and data registers are zero, the memory request is low, busy is low, and a read of the control register returns 0.
- R2: A transfer happens only when chip-select is low and exactly one of the two data strobes is low. With both data strobes low, or with chip-select high, a strobe pulse changes no register.
- R3: Select 00 addresses the control register and select 10 the address register. Half-word identifier 0 reaches bits 15:0 and 1 reaches bits 31:16. The address register keeps ADDR_W bits and reads back zero-extended.
- R4: Control and address register accesses never issue a memory request and never raise busy.
- R5: A write to the data register (select 11, or 01 with autoincrement) stores half 0 locally. On the rising strobe of half 1 it issues exactly one 32-bit memory write of {half 1, half 0} at the address register. The request and its address stay stable until acknowledged.
- R6: A read of the data register fetches the word at the address register on the falling strobe of half 0. Half 0 returns bits 15:0 and half 1 returns bits 31:16. With select 11 the address register is left unchanged.
- R7: A write through select 01 adds 4 to the address register once the memory write is acknowledged.
- R8: A read through select 01 adds 4 to the address register on the rising strobe of half 1 and prefetches the word at the new address.
- R9: Busy is high only while chip-select is low and a memory transfer is outstanding. This includes a transfer still pending from before chip-select fell. Busy is low whenever chip-select is high.
- R10: Strobe low and high pulses of two core clock cycles each complete their register accesses.
- R11: Address autoincrement wraps modulo 2^ADDR_W.
- R12: When the address strobe falls, the select inputs are captured. While it stays low, a later data strobe uses those captured selects instead of the live pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs_n | input | 1 | Host chip-select, active low |
| host_ds1_n | input | 1 | Host data strobe 1, active low |
| host_ds2_n | input | 1 | Host data strobe 2, active low |
| host_as_n | input | 1 | Host address strobe, active low; tie high when unused |
| host_sel | input | 2 | Register select (00 control, 01 data autoincrement, 10 address, 11 data) |
| host_rw | input | 1 | 1 = host read, 0 = host write |
| host_hw | input | 1 | Half-word identifier (0 first/low, 1 second/high) |
| host_wdata | input | 16 | Host write half-word |
| host_rdata | output | 16 | Host read half-word |
| host_busy | output | 1 | Stall request to the host, high while busy |
| mem_req | output | 1 | Memory channel request, held until acknowledged |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 32 | Memory write word |
| mem_ack | input | 1 | One-cycle acknowledge from the memory channel |
| mem_rdata | input | 32 | Memory read word, valid with mem_ack |

## Verification
The bench builds the block with an 18-bit address register and the default two synchronizer stages. The narrow address lets an autoincrement sequence starting four bytes below the top of the space reach the wrap to zero within a short run. The bench also sweeps memory latencies from zero to forty cycles. At the short end, acknowledges arrive while the synchronized strobe is still settling. At the long end, a write stays pending long enough for chip-select to be raised and lowered again around it.

// File: rtl/hps_pkg.sv
package hps_pkg;

    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'b00,
        SEL_DINC = 2'b01,
        SEL_ADDR = 2'b10,
        SEL_DATA = 2'b11
    } regsel_e;

    typedef struct packed {
        regsel_e rsel;
        logic    rd;
        logic    upper;
    } hsel_t;

    typedef struct packed {
        logic              cs_n;
        logic              ds1_n;
        logic              ds2_n;
        logic              as_n;
        hsel_t             sel;
        logic [HALF_W-1:0] wd;
    } pins_t;

    typedef struct packed {
        logic              fall;
        logic              rise;
        hsel_t             sel;
        logic [HALF_W-1:0] wd;
    } strobe_ev_t;

    localparam int PINS_W = $bits(pins_t);
    localparam logic [PINS_W-1:0] PINS_IDLE = {4'b1111, {(PINS_W-4){1'b0}}};

    function automatic logic is_data(regsel_e s);
        return (s == SEL_DINC) || (s == SEL_DATA);
    endfunction

    function automatic logic is_inc(regsel_e s);
        return s == SEL_DINC;
    endfunction

    function automatic logic [WORD_W-1:0] put_half(logic [WORD_W-1:0] w, logic upper,
                                                   logic [HALF_W-1:0] h);
        logic [WORD_W-1:0] r;
        r = w;
        if (upper) r[WORD_W-1:HALF_W] = h;
        else       r[HALF_W-1:0]      = h;
        return r;
    endfunction

    function automatic logic [HALF_W-1:0] get_half(logic [WORD_W-1:0] w, logic upper);
        return upper ? w[WORD_W-1:HALF_W] : w[HALF_W-1:0];
    endfunction

endpackage

// File: rtl/hps_sync.sv
module hps_sync #(
    parameter int             W       = 8,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hps_front.sv
module hps_front
    import hps_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pins_t      pins,
    output strobe_ev_t ev,
    output logic       cs_low,
    output hsel_t      hsel_q
);
    logic  stb_n, stb_prev, as_prev, as_fall;
    hsel_t sel_as, sel_now;

    // composite strobe: active low when selected and exactly one data strobe low
    assign stb_n   = ~(pins.ds1_n ^ pins.ds2_n) | pins.cs_n;
    assign as_fall = as_prev & ~pins.as_n;
    assign sel_now = (~pins.as_n && !as_fall) ? sel_as : pins.sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_prev <= 1'b1;
            as_prev  <= 1'b1;
            sel_as   <= '0;
            hsel_q   <= '0;
        end else begin
            stb_prev <= stb_n;
            as_prev  <= pins.as_n;
            if (as_fall) sel_as <= pins.sel;
            if (ev.fall) hsel_q <= sel_now;
        end
    end

    assign ev.fall = stb_prev & ~stb_n;
    assign ev.rise = ~stb_prev & stb_n;
    assign ev.sel  = ev.fall ? sel_now : hsel_q;
    assign ev.wd   = pins.wd;
    assign cs_low  = ~pins.cs_n;
endmodule

// File: rtl/hps_core.sv
module hps_core
    import hps_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  strobe_ev_t        ev,
    input  logic              cs_low,
    input  hsel_t             hsel_q,
    output logic [HALF_W-1:0] host_rdata,
    output logic              host_busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_W / 8);

    logic [WORD_W-1:0] ctrl_q, data_q;
    logic [ADDR_W-1:0] addr_q, maddr_q;
    logic              req_q, we_q, inc_q;
    logic              wr_ev, do_commit, do_fetch, do_prefetch, done;

    assign wr_ev       = ev.rise & ~ev.sel.rd;
    assign do_commit   = wr_ev & is_data(ev.sel.rsel) & ev.sel.upper & ~req_q;
    assign do_fetch    = ev.fall & ev.sel.rd & is_data(ev.sel.rsel) & ~ev.sel.upper & ~req_q;
    assign do_prefetch = ev.rise & ev.sel.rd & is_inc(ev.sel.rsel) & ev.sel.upper & ~req_q;
    assign done        = req_q & mem_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            data_q  <= '0;
            addr_q  <= '0;
            maddr_q <= '0;
            req_q   <= 1'b0;
            we_q    <= 1'b0;
            inc_q   <= 1'b0;
        end else begin
            if (done) begin
                req_q <= 1'b0;
                if (!we_q) data_q <= mem_rdata;
                if (inc_q) addr_q <= maddr_q + STEP;
            end
            if (wr_ev) begin
                case (ev.sel.rsel)
                    SEL_CTRL: ctrl_q <= put_half(ctrl_q, ev.sel.upper, ev.wd);
                    SEL_ADDR: addr_q <= ADDR_W'(put_half(WORD_W'(addr_q), ev.sel.upper, ev.wd));
                    default:  if (!req_q) data_q <= put_half(data_q, ev.sel.upper, ev.wd);
                endcase
            end
            if (do_commit) begin
                req_q   <= 1'b1;
                we_q    <= 1'b1;
                maddr_q <= addr_q;
                inc_q   <= is_inc(ev.sel.rsel);
            end
            if (do_fetch) begin
                req_q   <= 1'b1;
                we_q    <= 1'b0;
                maddr_q <= addr_q;
                inc_q   <= 1'b0;
            end
            if (do_prefetch) begin
                req_q   <= 1'b1;
                we_q    <= 1'b0;
                maddr_q <= addr_q + STEP;
                addr_q  <= addr_q + STEP;
                inc_q   <= 1'b0;
            end
        end
    end

    always_comb begin
        host_rdata = '0;
        if (hsel_q.rd) begin
            case (hsel_q.rsel)
                SEL_CTRL: host_rdata = get_half(ctrl_q, hsel_q.upper);
                SEL_ADDR: host_rdata = get_half(WORD_W'(addr_q), hsel_q.upper);
                default:  host_rdata = get_half(data_q, hsel_q.upper);
            endcase
        end
    end

    assign host_busy = cs_low & req_q;
    assign mem_req   = req_q;
    assign mem_we    = we_q;
    assign mem_addr  = maddr_q;
    assign mem_wdata = data_q;

    // request and its payload stay put until the channel acknowledges
    assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

    // only data register traffic may start a memory transfer
    assert_req_data_only_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> ($past(ev.fall || ev.rise) && is_data($past(ev.sel.rsel))));

    // an acknowledged autoincrement write advances the address by one word
    assert_inc_step_R7: assert property (@(posedge clk) disable iff (rst)
        (done && we_q && inc_q && !wr_ev) |=> (addr_q == $past(mem_addr) + STEP));
endmodule

// File: rtl/hostport_slave.sv
module hostport_slave
    import hps_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_cs_n,
    input  logic              host_ds1_n,
    input  logic              host_ds2_n,
    input  logic              host_as_n,
    input  logic [1:0]        host_sel,
    input  logic              host_rw,
    input  logic              host_hw,
    input  logic [15:0]       host_wdata,
    output logic [15:0]       host_rdata,
    output logic              host_busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata
);
    pins_t      pins_raw, pins_s;
    strobe_ev_t ev;
    hsel_t      hsel_q;
    logic       cs_low;
    logic [PINS_W-1:0] sync_q;

    assign pins_raw.cs_n      = host_cs_n;
    assign pins_raw.ds1_n     = host_ds1_n;
    assign pins_raw.ds2_n     = host_ds2_n;
    assign pins_raw.as_n      = host_as_n;
    assign pins_raw.sel.rsel  = regsel_e'(host_sel);
    assign pins_raw.sel.rd    = host_rw;
    assign pins_raw.sel.upper = host_hw;
    assign pins_raw.wd        = host_wdata;

    hps_sync #(.W(PINS_W), .STAGES(SYNC_STAGES), .RST_VAL(PINS_IDLE)) u_sync (
        .clk(clk), .rst(rst), .d(pins_raw), .q(sync_q)
    );
    assign pins_s = pins_t'(sync_q);

    hps_front u_front (
        .clk(clk), .rst(rst), .pins(pins_s), .ev(ev), .cs_low(cs_low), .hsel_q(hsel_q)
    );

    hps_core #(.ADDR_W(ADDR_W)) u_core (
        .clk(clk), .rst(rst), .ev(ev), .cs_low(cs_low), .hsel_q(hsel_q),
        .host_rdata(host_rdata), .host_busy(host_busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // busy never shows while the synchronized chip-select is high
    assert_busy_gate_R9: assert property (@(posedge clk) disable iff (rst)
        !cs_low |-> !host_busy);

    // a transfer left pending shows as busy as soon as chip-select returns
    assert_pend_busy_R9: assert property (@(posedge clk) disable iff (rst)
        ($rose(cs_low) && mem_req) |-> host_busy);
endmodule

// File: tb/hostport_slave_test.sv
`timescale 1ns/1ps
module hostport_slave_test;
    localparam int AW = 18;
    localparam logic [31:0] AMASK = (32'd1 << AW) - 1;

    logic clk = 1'b0, rst = 1'b1;
    logic cs_n = 1'b1, ds1_n = 1'b1, ds2_n = 1'b1, as_n = 1'b1;
    logic [1:0] sel = 2'b00;
    logic rw = 1'b0, hw = 1'b0;
    logic [15:0] wd = '0;
    logic [15:0] rdata;
    logic busy, mem_req, mem_we, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;

    int vectors = 0, fails = 0, lat = 0, wait_c = 0;
    int wr_cnt = 0, rd_cnt = 0;
    logic [31:0] last_wa = '0, last_wd = '0, last_ra = '0;
    logic busy_seen;
    bit done_flag = 0;

    always #2 clk = ~clk;

    hostport_slave #(.ADDR_W(AW), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .host_cs_n(cs_n), .host_ds1_n(ds1_n), .host_ds2_n(ds2_n),
        .host_as_n(as_n), .host_sel(sel), .host_rw(rw), .host_hw(hw), .host_wdata(wd),
        .host_rdata(rdata), .host_busy(busy), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] memf(logic [31:0] a);
        return a * 32'h0001_9E37 + 32'h1234_5678;
    endfunction

    // memory channel model with programmable latency
    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0; mem_rdata <= '0; wait_c <= 0;
        end else begin
            mem_ack <= 1'b0;
            if (mem_req && !mem_ack) begin
                if (wait_c >= lat) begin
                    mem_ack <= 1'b1;
                    wait_c  <= 0;
                    if (mem_we) begin
                        wr_cnt <= wr_cnt + 1; last_wa <= 32'(mem_addr); last_wd <= mem_wdata;
                    end else begin
                        rd_cnt <= rd_cnt + 1; last_ra <= 32'(mem_addr);
                        mem_rdata <= memf(32'(mem_addr));
                    end
                end else wait_c <= wait_c + 1;
            end
        end
    end

    task automatic summary();
        if (!done_flag) begin
            done_flag = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        #600000;
        vectors++; fails++;
        $display("FAIL watchdog: run hung, act=running exp=finished");
        summary();
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_ready();
        int t = 0;
        while (busy && t < 5000) begin tick(1); t++; end
        if (t >= 5000) check("R9 busy timeout", 32'(busy), 32'd0);
    endtask

    task automatic hstb(input logic [1:0] s, input logic rd, input logic up,
                        input logic [15:0] w, input int lo, input int hi,
                        input logic use2, output logic [15:0] r);
        sel = s; rw = rd; hw = up; wd = w;
        tick(1);
        if (use2) ds2_n = 1'b0; else ds1_n = 1'b0;
        tick(lo);
        busy_seen = busy;
        wait_ready();
        r = rdata;
        ds1_n = 1'b1; ds2_n = 1'b1;
        tick(hi);
    endtask

    task automatic settle();
        tick(4); wait_ready();
    endtask

    task automatic wr32(input logic [1:0] s, input logic [31:0] v, input int lo, input int hi);
        logic [15:0] d;
        hstb(s, 1'b0, 1'b0, v[15:0], lo, hi, 1'b0, d);
        hstb(s, 1'b0, 1'b1, v[31:16], lo, hi, 1'b0, d);
        settle();
    endtask

    task automatic rd32(input logic [1:0] s, output logic [31:0] v);
        logic [15:0] lo_h, hi_h;
        hstb(s, 1'b1, 1'b0, 16'h0, 4, 4, 1'b0, lo_h);
        hstb(s, 1'b1, 1'b1, 16'h0, 4, 4, 1'b0, hi_h);
        settle();
        v = {hi_h, lo_h};
    endtask

    initial begin
        logic [31:0] v, a, pat;
        logic [15:0] d;
        int c0, busy_any;

        tick(6);
        // R1: reset state
        check("R1 busy after reset", 32'(busy), 32'd0);
        check("R1 mem_req after reset", 32'(mem_req), 32'd0);
        rst = 1'b0;
        tick(2);
        cs_n = 1'b0;
        tick(3);
        rd32(2'b00, v); check("R1 control reset value", v, 32'h0);
        rd32(2'b10, v); check("R1 address reset value", v, 32'h0);

        // R3/R4: sweep patterns through control and address registers
        c0 = wr_cnt + rd_cnt; busy_any = 0;
        for (int k = 0; k < 16; k++) begin
            pat = (32'hF0E1_D2C3 >> k) ^ (32'h0101_0101 * k) ^ (32'h8000_0001 << (k % 3));
            wr32(2'b00, pat, 4, 4);
            busy_any = busy_any | int'(busy_seen);
            wr32(2'b10, ~pat, 4, 4);
            rd32(2'b00, v); check("R3 control word", v, pat);
            busy_any = busy_any | int'(busy_seen);
            rd32(2'b10, v); check("R3 address word masked", v, ~pat & AMASK);
        end
        // R3: upper half alone leaves lower half intact
        wr32(2'b00, 32'h1111_2222, 4, 4);
        hstb(2'b00, 1'b0, 1'b1, 16'hABCD, 4, 4, 1'b0, d);
        settle();
        rd32(2'b00, v); check("R3 upper half only", v, 32'hABCD_2222);
        check("R4 no memory traffic from control/address", 32'(wr_cnt + rd_cnt), 32'(c0));
        check("R4 busy never raised", 32'(busy_any), 32'd0);

        // R2: both data strobes low is no strobe
        sel = 2'b00; rw = 1'b0; hw = 1'b0; wd = 16'hFFFF; tick(1);
        ds1_n = 1'b0; ds2_n = 1'b0; tick(4); ds1_n = 1'b1; ds2_n = 1'b1; tick(4);
        // R2: chip-select high blocks a strobe
        cs_n = 1'b1; tick(1); ds1_n = 1'b0; tick(4); ds1_n = 1'b1; tick(4); cs_n = 1'b0; tick(3);
        rd32(2'b00, v); check("R2 invalid strobes ignored", v, 32'hABCD_2222);
        // R2: second data strobe alone is a valid strobe
        hstb(2'b00, 1'b0, 1'b0, 16'h5A5A, 4, 4, 1'b1, d);
        settle();
        rd32(2'b00, v); check("R2 strobe via second data strobe", v, 32'hABCD_5A5A);

        // R5/R6: plain data register writes and reads across latencies
        for (int l = 0; l < 4; l++) begin
            lat = l;
            for (int j = 0; j < 3; j++) begin
                a = (32'h0001_2340 + 32'(j * 32'h1F0 + l * 8)) & AMASK;
                pat = memf(a) ^ 32'hC3C3_0F0F;
                wr32(2'b10, a, 4, 4);
                c0 = wr_cnt;
                hstb(2'b11, 1'b0, 1'b0, pat[15:0], 4, 4, 1'b0, d);
                settle();
                check("R5 no write after first half", 32'(wr_cnt), 32'(c0));
                hstb(2'b11, 1'b0, 1'b1, pat[31:16], 4, 4, 1'b0, d);
                settle();
                check("R5 one write per pair", 32'(wr_cnt), 32'(c0 + 1));
                check("R5 write address", last_wa, a);
                check("R5 write word", last_wd, pat);
                c0 = rd_cnt;
                rd32(2'b11, v);
                check("R6 fetched word", v, memf(a));
                check("R6 one fetch per pair", 32'(rd_cnt), 32'(c0 + 1));
                rd32(2'b10, v); check("R6 address unchanged", v, a);
            end
        end

        // R7: autoincrement writes
        lat = 2;
        a = 32'h0000_8000;
        wr32(2'b10, a, 4, 4);
        for (int j = 0; j < 3; j++) begin
            wr32(2'b01, 32'hBEEF_0000 + 32'(j), 4, 4);
            check("R7 autoinc write address", last_wa, a + 32'(4 * j));
        end
        rd32(2'b10, v); check("R7 address advanced by 12", v, a + 32'd12);

        // R8: autoincrement reads with prefetch
        a = 32'h0000_9000;
        wr32(2'b10, a, 4, 4);
        rd32(2'b01, v); check("R8 first word", v, memf(a));
        check("R8 prefetch address", last_ra, a + 32'd4);
        rd32(2'b01, v); check("R8 second word", v, memf(a + 32'd4));
        rd32(2'b10, v); check("R8 address advanced", v, a + 32'd8);

        // R11: wrap at the top of the address space
        a = AMASK - 32'd3;
        wr32(2'b10, a, 4, 4);
        wr32(2'b01, 32'h0F0F_F0F0, 4, 4);
        check("R11 write at top address", last_wa, a);
        rd32(2'b10, v); check("R11 address wrapped", v, 32'h0);

        // R9: busy during a long fetch, and gating by chip-select for a pending write
        lat = 40;
        wr32(2'b10, 32'h100, 4, 4);
        hstb(2'b11, 1'b1, 1'b0, 16'h0, 4, 4, 1'b0, d);
        check("R9 busy during fetch", 32'(busy_seen), 32'd1);
        check("R9 fetched half", 32'(d), 32'(memf(32'h100) & 32'hFFFF));
        settle();
        c0 = wr_cnt;
        hstb(2'b11, 1'b0, 1'b0, 16'h7777, 4, 4, 1'b0, d);
        hstb(2'b11, 1'b0, 1'b1, 16'h8888, 4, 4, 1'b0, d);
        check("R9 busy after second write half", 32'(busy), 32'd1);
        cs_n = 1'b1; tick(3);
        check("R9 busy low with chip-select high", 32'(busy), 32'd0);
        cs_n = 1'b0; tick(3);
        check("R9 busy on chip-select fall while pending", 32'(busy), 32'd1);
        wait_ready();
        check("R9 busy clears on completion", 32'(busy), 32'd0);
        check("R9 pending write landed", last_wd, 32'h8888_7777);
        check("R9 one write", 32'(wr_cnt), 32'(c0 + 1));

        // R10: two-cycle strobe pulses
        lat = 0;
        wr32(2'b00, 32'h2468_ACE0, 2, 2);
        rd32(2'b00, v); check("R10 short pulse write", v, 32'h2468_ACE0);

        // R12: selects captured by the address strobe
        wr32(2'b10, 32'h0, 4, 4);
        sel = 2'b10; rw = 1'b0; hw = 1'b0; tick(1);
        as_n = 1'b0; tick(3);
        sel = 2'b00; rw = 1'b1; hw = 1'b1; wd = 16'h3C3C; tick(1);
        ds1_n = 1'b0; tick(4); ds1_n = 1'b1; tick(4);
        as_n = 1'b1; tick(3);
        rd32(2'b10, v); check("R12 address takes captured select", v, 32'h3C3C);
        rd32(2'b00, v); check("R12 control untouched", v, 32'h2468_ACE0);

        tick(4);
        summary();
    end
endmodule